// File: doc/BRIEF.md
# Register-write command stream executor

The block is a small DMA-style sequencer. It walks a command buffer in memory, starting at a head byte address and stopping at a tail byte address, and turns the buffer into register write transactions on a local register bus. Software enables the block through a control register, loads the head, and then writes the tail. That tail write starts execution. The engine never reads a register. It only fetches command words from memory and issues writes.

Every instruction is two 32-bit words on an 8-byte boundary. The lower word is fetched first and the upper word second. The upper word carries the opcode in bits [31:24]. A single write carries a byte-enable field and a 20-bit register offset. An indexed write carries a count in its lower word. That many data words follow, all written to one offset, with a zero pad word when the count is odd. A wait instruction holds the engine for a number of vblank pulses. Zero words decode as no-ops, so the space between the last instruction and a line-aligned tail is harmless.

The memory read port has two valid/ready channels. On the request channel, `mem_req_valid` with `mem_req_addr` stays asserted and stable until `mem_req_ready`. Only one request is outstanding at a time. The response channel accepts one word per request while `mem_rsp_ready` is high. On the register bus, `reg_valid` with `reg_addr`, `reg_data` and `reg_be` stays asserted and stable until `reg_ready`. The single exception is an abort, which withdraws the write. Control and status pins are plain.

Top module: `cmdq_exec`

## Requirements
- R1: After reset, `busy`, `err_tail`, `err_op`, `mem_req_valid` and `reg_valid` are all 0.
- R2: A configuration write with `cfg_sel`=2 (tail) starts execution when all of the following hold:
  - control bit 0 (enable) is 1;
  - the value is a multiple of 64;
  - the engine is idle.
  
  After a start, `busy` is 1 in the next cycle and the first fetch is from the head address (`cfg_sel`=1, bits [2:0] forced to 0). A tail write whose low 6 bits are not zero does not start the engine and sets the sticky `err_tail`. A tail write while enable is 0 does not start the engine.
- R3: An instruction's lower word is read from its address and its upper word from address+4. With opcode 0x01 in upper bits [31:24], one register write is issued:
  - `reg_data` is the lower word;
  - `reg_be` is upper bits [23:20];
  - `reg_addr` is upper bits [19:0].
- R4: Opcode 0x09 takes N from lower bits [15:0]. It writes the N words that follow to offset upper[19:0], each with `reg_be`=4'hF, in order. When N is odd, the one pad word after the data is skipped without being read. N=0 writes nothing.
- R5: Opcode 0x00 issues no register write, whatever its lower word holds. An all-zero area therefore executes as no-ops.
- R6: Any opcode other than 0x00, 0x01, 0x04 and 0x09 issues no write, is skipped, and sets the sticky `err_op`.
- R7: Opcode 0x04 waits for K rising `vblank` cycles, where K is lower bits [7:0], before the next instruction is fetched. K=0 does not wait.
- R8: When control bit 1 is set at start, no memory request is made until a `vblank` pulse arrives.
- R9: `busy` stays 1 until the fetch address equals the tail at an instruction boundary, and then falls to 0. With head equal to tail, the engine makes no memory read. No register write is issued while `busy` is 0.
- R10: A control write with bit 0 equal to 0 returns the engine to idle in the next cycle. It drops `reg_valid` and clears both sticky error flags. A memory response still outstanding is absorbed and discarded.
- R11: Once raised, `mem_req_valid` and its address stay stable until accepted. A raised `reg_valid` and its payload stay stable until accepted, unless an abort intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 head, 2 tail |
| cfg_wdata | input | 32 | Configuration write data |
| vblank | input | 1 | Vertical blank pulse |
| busy | output | 1 | Engine executing |
| err_tail | output | 1 | Sticky misaligned-tail flag |
| err_op | output | 1 | Sticky unsupported-opcode flag |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | AW | Byte address of requested word |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Engine accepts response |
| mem_rsp_data | input | 32 | Returned word |
| reg_valid | output | 1 | Register write valid |
| reg_ready | input | 1 | Register write accepted |
| reg_addr | output | 20 | Register offset |
| reg_data | output | 32 | Register write data |
| reg_be | output | 4 | Byte enables |

## Verification
The hardest state to reach from the ports is an abort that lands while a register write is stalled and a memory fetch may still be in flight. The response must be absorbed, not mistaken for a new instruction. The bench holds `reg_ready` low during a long indexed burst until `reg_valid` appears, aborts at that moment, and then releases the bus. It then confirms that no write leaks out and that the next program runs cleanly. The odd-count pad skip is driven under pseudo-random back-pressure on both channels. It is checked both through the exact memory read count and through the correct decoding of the instruction after the pad.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int RAW = 20;
  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_WR  = 8'h01;
  localparam logic [7:0] OP_WVB = 8'h04;
  localparam logic [7:0] OP_IDX = 8'h09;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_TAIL = 2'd2;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} fetch_st_t;

  typedef enum logic [3:0] {
    S_IDLE, S_GATE, S_LO, S_LOW, S_HI, S_HIW, S_WR, S_IDX, S_IDXW, S_VWT
  } seq_st_t;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LINEB = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          busy,
  output logic          vbgate_q,
  output logic [AW-1:0] head_q,
  output logic [AW-1:0] tail_q,
  output logic          start,
  output logic          abort,
  output logic          err_tail_q
);
  localparam int LW = $clog2(LINEB);

  logic en_q;
  logic wr_ctrl, wr_head, wr_tail, tail_ok;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata;
  assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
  assign wr_head = cfg_we && (cfg_sel == SEL_HEAD);
  assign wr_tail = cfg_we && (cfg_sel == SEL_TAIL);
  assign tail_ok = (cfg_wdata[LW-1:0] == '0);
  assign abort   = wr_ctrl && !cfg_wdata[0];
  assign start   = wr_tail && tail_ok && en_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      vbgate_q   <= 1'b0;
      head_q     <= '0;
      tail_q     <= '0;
      err_tail_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q     <= cfg_wdata[0];
        vbgate_q <= cfg_wdata[1];
      end
      if (abort) err_tail_q <= 1'b0;
      if (wr_head) head_q <= {cfg_wdata[AW-1:3], 3'b000};
      if (start) tail_q <= cfg_wdata[AW-1:0];
      if (wr_tail && !tail_ok) err_tail_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
  import cmdq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  input  logic          abort,
  output logic          idle,
  output logic          done,
  output logic [31:0]   word,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [31:0]   mem_rsp_data
);
  fetch_st_t     st;
  logic          drop_q;
  logic [AW-1:0] addr_q;

  assign idle          = (st == F_IDLE);
  assign mem_req_valid = (st == F_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (st == F_RSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      drop_q <= 1'b0;
      addr_q <= '0;
      done   <= 1'b0;
      word   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        F_IDLE: begin
          if (go && !abort) begin
            addr_q <= go_addr;
            drop_q <= 1'b0;
            st     <= F_REQ;
          end
        end
        F_REQ: begin
          if (abort) drop_q <= 1'b1;
          if (mem_req_ready) st <= F_RSP;
        end
        F_RSP: begin
          if (abort) drop_q <= 1'b1;
          if (mem_rsp_valid) begin
            st <= F_IDLE;
            if (!(drop_q || abort)) begin
              done <= 1'b1;
              word <= mem_rsp_data;
            end
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CNTW = 16,
  parameter int VBW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           abort,
  input  logic           vbgate,
  input  logic [AW-1:0]  head,
  input  logic [AW-1:0]  tail,
  input  logic           vblank,
  input  logic           f_idle,
  input  logic           f_done,
  input  logic [31:0]    f_word,
  output logic           f_go,
  output logic [AW-1:0]  f_addr,
  output logic           reg_valid,
  input  logic           reg_ready,
  output logic [RAW-1:0] reg_addr,
  output logic [31:0]    reg_data,
  output logic [3:0]     reg_be,
  output logic           busy,
  output logic           err_op_q
);
  localparam logic [AW-1:0] STEP = AW'(4);

  seq_st_t        st;
  logic [AW-1:0]  ptr;
  logic [31:0]    lo_q;
  logic [RAW-1:0] wa_q;
  logic [31:0]    wd_q;
  logic [3:0]     wbe_q;
  logic [CNTW-1:0] cnt_q;
  logic           odd_q;
  logic           idx_q;
  logic [VBW-1:0] vbc_q;
  logic           at_tail;
  logic [7:0]     op;

  assign at_tail   = (ptr == tail);
  assign op        = f_word[31:24];
  assign f_addr    = ptr;
  assign f_go      = f_idle && ((st == S_LO && !at_tail) || (st == S_HI) ||
                                (st == S_IDX && cnt_q != '0 && !at_tail));
  assign reg_valid = (st == S_WR);
  assign reg_addr  = wa_q;
  assign reg_data  = wd_q;
  assign reg_be    = wbe_q;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      lo_q     <= '0;
      wa_q     <= '0;
      wd_q     <= '0;
      wbe_q    <= '0;
      cnt_q    <= '0;
      odd_q    <= 1'b0;
      idx_q    <= 1'b0;
      vbc_q    <= '0;
      err_op_q <= 1'b0;
    end else if (abort) begin
      st       <= S_IDLE;
      err_op_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start) begin
            ptr <= head;
            st  <= vbgate ? S_GATE : S_LO;
          end
        end
        S_GATE: if (vblank) st <= S_LO;
        S_LO: begin
          if (at_tail) st <= S_IDLE;
          else if (f_idle) st <= S_LOW;
        end
        S_LOW: begin
          if (f_done) begin
            lo_q <= f_word;
            ptr  <= ptr + STEP;
            st   <= S_HI;
          end
        end
        S_HI: if (f_idle) st <= S_HIW;
        S_HIW: begin
          if (f_done) begin
            ptr <= ptr + STEP;
            if (op == OP_NOP) begin
              st <= S_LO;
            end else if (op == OP_WR) begin
              wa_q  <= f_word[RAW-1:0];
              wbe_q <= f_word[23:20];
              wd_q  <= lo_q;
              idx_q <= 1'b0;
              st    <= S_WR;
            end else if (op == OP_IDX) begin
              wa_q  <= f_word[RAW-1:0];
              wbe_q <= 4'hF;
              cnt_q <= lo_q[CNTW-1:0];
              odd_q <= lo_q[0];
              idx_q <= 1'b1;
              st    <= S_IDX;
            end else if (op == OP_WVB) begin
              vbc_q <= lo_q[VBW-1:0];
              st    <= S_VWT;
            end else begin
              err_op_q <= 1'b1;
              st       <= S_LO;
            end
          end
        end
        S_IDX: begin
          if (cnt_q == '0) begin
            if (odd_q && !at_tail) ptr <= ptr + STEP;
            st <= S_LO;
          end else if (at_tail) begin
            st <= S_IDLE;
          end else if (f_idle) begin
            st <= S_IDXW;
          end
        end
        S_IDXW: begin
          if (f_done) begin
            wd_q  <= f_word;
            ptr   <= ptr + STEP;
            cnt_q <= cnt_q - 1'b1;
            st    <= S_WR;
          end
        end
        S_WR: if (reg_ready) st <= idx_q ? S_IDX : S_LO;
        S_VWT: begin
          if (vbc_q == '0) st <= S_LO;
          else if (vblank) vbc_q <= vbc_q - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
  import cmdq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LINEB = 64,
  parameter int CNTW  = 16,
  parameter int VBW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  input  logic           vblank,
  output logic           busy,
  output logic           err_tail,
  output logic           err_op,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  output logic           mem_rsp_ready,
  input  logic [31:0]    mem_rsp_data,
  output logic           reg_valid,
  input  logic           reg_ready,
  output logic [RAW-1:0] reg_addr,
  output logic [31:0]    reg_data,
  output logic [3:0]     reg_be
);
  logic          vbgate, start, abort;
  logic [AW-1:0] head, tail, f_addr;
  logic          f_idle, f_done, f_go;
  logic [31:0]   f_word;

  cmdq_regs #(.AW(AW), .LINEB(LINEB)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .vbgate_q(vbgate), .head_q(head),
    .tail_q(tail), .start(start), .abort(abort), .err_tail_q(err_tail)
  );

  cmdq_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(f_go), .go_addr(f_addr), .abort(abort),
    .idle(f_idle), .done(f_done), .word(f_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  cmdq_seq #(.AW(AW), .CNTW(CNTW), .VBW(VBW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .vbgate(vbgate),
    .head(head), .tail(tail), .vblank(vblank), .f_idle(f_idle),
    .f_done(f_done), .f_word(f_word), .f_go(f_go), .f_addr(f_addr),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_addr(reg_addr),
    .reg_data(reg_data), .reg_be(reg_be), .busy(busy), .err_op_q(err_op)
  );
endmodule

// File: rtl/cmdq_exec_chk.sv
module cmdq_exec_chk #(
  parameter int AW    = 16,
  parameter int LINEB = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [31:0]   cfg_wdata,
  input logic          busy,
  input logic          err_tail,
  input logic          err_op,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          reg_valid,
  input logic          reg_ready,
  input logic [19:0]   reg_addr,
  input logic [31:0]   reg_data,
  input logic [3:0]    reg_be
);
  localparam int LW = $clog2(LINEB);
  logic abort_in, bad_tail;
  logic unused_chk;

  assign unused_chk = ^cfg_wdata;
  assign abort_in = cfg_we && (cfg_sel == 2'd0) && !cfg_wdata[0];
  assign bad_tail = cfg_we && (cfg_sel == 2'd2) && (cfg_wdata[LW-1:0] != '0);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready && !abort_in |=>
      reg_valid && $stable(reg_addr) && $stable(reg_data) && $stable(reg_be));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_in |=> !busy && !reg_valid && !err_tail && !err_op);

  p_bad_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_tail |=> err_tail);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_valid);

  p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
endmodule

bind cmdq_exec cmdq_exec_chk #(.AW(AW), .LINEB(LINEB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .busy(busy), .err_tail(err_tail), .err_op(err_op),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .reg_valid(reg_valid), .reg_ready(reg_ready),
  .reg_addr(reg_addr), .reg_data(reg_data), .reg_be(reg_be)
);

// File: tb/sim_cmdq_exec.sv
`timescale 1ns/1ps
module sim_cmdq_exec;
  localparam int AW = 16;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] data;
    logic [19:0] addr;
    logic [3:0]  be;
    logic [1:0]  nw;
    logic        eop;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{32'hDEADBEEF, 32'h01F12345, 32'hDEADBEEF, 20'h12345, 4'hF, 2'd1, 1'b0},
    '{32'h0000A5A5, 32'h01300ABC, 32'h0000A5A5, 20'h00ABC, 4'h3, 2'd1, 1'b0},
    '{32'h12345678, 32'h00000000, 32'h0,        20'h0,     4'h0, 2'd0, 1'b0},
    '{32'h00000000, 32'h02000010, 32'h0,        20'h0,     4'h0, 2'd0, 1'b1},
    '{32'h00000000, 32'h0A000010, 32'h0,        20'h0,     4'h0, 2'd0, 1'b1},
    '{32'h00000000, 32'hFF000010, 32'h0,        20'h0,     4'h0, 2'd0, 1'b1},
    '{32'h00000000, 32'h04000000, 32'h0,        20'h0,     4'h0, 2'd0, 1'b0},
    '{32'h00000007, 32'h016FFFFF, 32'h00000007, 20'hFFFFF, 4'h6, 2'd1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic vblank = 1'b0;
  logic busy, err_tail, err_op;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_rsp_data;
  logic reg_valid, reg_ready;
  logic [19:0] reg_addr;
  logic [31:0] reg_data;
  logic [3:0] reg_be;

  logic bp_en = 1'b0, stall_reg = 1'b0;
  logic [3:0] bp;
  logic [31:0] mem [256];
  int nreads, wr_n, nchk = 0, nfail = 0, cyc = 0;
  logic [19:0] lg_a [64];
  logic [31:0] lg_d [64];
  logic [3:0]  lg_b [64];

  always #2 clk = ~clk;

  cmdq_exec u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .vblank(vblank), .busy(busy), .err_tail(err_tail),
    .err_op(err_op), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_addr(reg_addr),
    .reg_data(reg_data), .reg_be(reg_be)
  );

  assign mem_req_ready = !bp_en || bp[0];
  assign reg_ready     = !stall_reg && (!bp_en || bp[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp <= 4'b1001; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      nreads <= 0; wr_n <= 0;
    end else begin
      bp <= {bp[2:0], bp[3] ^ bp[2]};
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
        nreads <= nreads + 1;
      end
      if (reg_valid && reg_ready) begin
        lg_a[wr_n[5:0]] <= reg_addr;
        lg_d[wr_n[5:0]] <= reg_data;
        lg_b[wr_n[5:0]] <= reg_be;
        wr_n <= wr_n + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic put(input int byte_addr, input logic [31:0] w);
    mem[byte_addr / 4] = w;
  endtask

  task automatic launch(input int head, input int tail, input logic [31:0] ctrl);
    cfg(2'd0, 32'h0);
    cfg(2'd0, ctrl);
    cfg(2'd1, 32'(head));
    cfg(2'd2, 32'(tail));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic pulse_vb();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0, w0;
    clear_mem();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req_valid", 32'(mem_req_valid), 0);
    chk("R1 reg_valid", 32'(reg_valid), 0);
    chk("R1 err flags", {30'b0, err_tail, err_op}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R3, R5, R6, R7 zero wait, R9, R11 under back-pressure
    for (int k = 0; k < 8; k++) begin
      clear_mem();
      put(0, VT[k].lo); put(4, VT[k].hi);
      bp_en = k[0];
      r0 = nreads; w0 = wr_n;
      launch(0, 32'h40, 32'h1);
      chk("R2 busy after start", 32'(busy), 1);
      wait_idle();
      chk("R9 busy cleared", 32'(busy), 0);
      chk("R3 read count", 32'(nreads - r0), 16);
      chk("R3 R5 write count", 32'(wr_n - w0), 32'(VT[k].nw));
      if (VT[k].nw != 0) begin
        chk("R3 addr", 32'(lg_a[w0[5:0]]), 32'(VT[k].addr));
        chk("R3 data", lg_d[w0[5:0]], VT[k].data);
        chk("R3 be", 32'(lg_b[w0[5:0]]), 32'(VT[k].be));
      end
      chk("R6 err_op", 32'(err_op), 32'(VT[k].eop));
    end

    // R4 odd count with pad, then a single write, under R11 back-pressure
    clear_mem(); bp_en = 1'b1;
    put(32'h100, 3); put(32'h104, 32'h09000200);
    put(32'h108, 32'h11); put(32'h10C, 32'h22); put(32'h110, 32'h33);
    put(32'h114, 32'hFFFFFFFF);
    put(32'h118, 32'hAA); put(32'h11C, 32'h01F00300);
    r0 = nreads; w0 = wr_n;
    launch(32'h100, 32'h140, 32'h1);
    wait_idle();
    chk("R4 odd write count", 32'(wr_n - w0), 4);
    chk("R4 pad not read", 32'(nreads - r0), 15);
    chk("R4 d0", lg_d[w0[5:0]], 32'h11);
    chk("R4 d1", lg_d[6'(w0 + 1)], 32'h22);
    chk("R4 d2", lg_d[6'(w0 + 2)], 32'h33);
    chk("R4 a2", 32'(lg_a[6'(w0 + 2)]), 32'h200);
    chk("R4 be", 32'(lg_b[6'(w0 + 1)]), 32'hF);
    chk("R11 after pad addr", 32'(lg_a[6'(w0 + 3)]), 32'h300);
    chk("R11 after pad data", lg_d[6'(w0 + 3)], 32'hAA);
    chk("R6 no err", 32'(err_op), 0);

    // R4 even count
    clear_mem();
    put(32'h100, 2); put(32'h104, 32'h09000400);
    put(32'h108, 5); put(32'h10C, 6);
    put(32'h110, 32'hBB); put(32'h114, 32'h01F00500);
    r0 = nreads; w0 = wr_n;
    launch(32'h100, 32'h140, 32'h1);
    wait_idle();
    chk("R4 even write count", 32'(wr_n - w0), 3);
    chk("R4 even read count", 32'(nreads - r0), 16);
    chk("R4 even d1", lg_d[6'(w0 + 1)], 32'h6);
    chk("R4 even next addr", 32'(lg_a[6'(w0 + 2)]), 32'h500);

    // R4 zero count
    clear_mem(); bp_en = 1'b0;
    put(32'h180, 0); put(32'h184, 32'h09000600);
    put(32'h188, 32'hCC); put(32'h18C, 32'h01F00700);
    w0 = wr_n;
    launch(32'h180, 32'h1C0, 32'h1);
    wait_idle();
    chk("R4 zero count writes", 32'(wr_n - w0), 1);
    chk("R4 zero count addr", 32'(lg_a[w0[5:0]]), 32'h700);

    // R8 start gate
    clear_mem();
    put(32'h180, 32'h5A); put(32'h184, 32'h01F00900);
    r0 = nreads; w0 = wr_n;
    launch(32'h180, 32'h1C0, 32'h3);
    wait_cyc(20);
    chk("R8 no fetch before vblank", 32'(nreads - r0), 0);
    chk("R8 busy while gated", 32'(busy), 1);
    pulse_vb();
    wait_idle();
    chk("R8 write after vblank", 32'(wr_n - w0), 1);

    // R7 wait two vblanks
    clear_mem();
    put(32'h180, 2); put(32'h184, 32'h04000000);
    put(32'h188, 32'hDD); put(32'h18C, 32'h01F00800);
    w0 = wr_n;
    launch(32'h180, 32'h1C0, 32'h1);
    wait_cyc(30);
    chk("R7 held before first", 32'(wr_n - w0), 0);
    pulse_vb();
    wait_cyc(30);
    chk("R7 held after first", 32'(wr_n - w0), 0);
    chk("R7 still busy", 32'(busy), 1);
    pulse_vb();
    wait_idle();
    chk("R7 write after second", 32'(wr_n - w0), 1);

    // R2 misaligned tail
    r0 = nreads;
    launch(32'h180, 32'h1C4, 32'h1);
    chk("R2 misaligned no start", 32'(busy), 0);
    chk("R2 err_tail set", 32'(err_tail), 1);
    cfg(2'd2, 32'h1C0);
    chk("R2 err_tail sticky", 32'(err_tail), 1);
    wait_idle();

    // R2 disabled tail write
    cfg(2'd0, 32'h0);
    r0 = nreads;
    cfg(2'd2, 32'h1C0);
    wait_cyc(10);
    chk("R2 disabled no start", 32'(busy), 0);
    chk("R2 disabled no reads", 32'(nreads - r0), 0);

    // R10 abort mid-burst
    clear_mem();
    put(32'h200, 20); put(32'h204, 32'h09000A00);
    for (int i = 0; i < 20; i++) put(32'h208 + 4 * i, 32'h1000 + i);
    stall_reg = 1'b1;
    launch(32'h200, 32'h280, 32'h1);
    for (int i = 0; i < 2000 && !reg_valid; i++) @(negedge clk);
    chk("R10 stalled write present", 32'(reg_valid), 1);
    cfg(2'd2, 32'h204);
    chk("R10 err_tail before abort", 32'(err_tail), 1);
    w0 = wr_n;
    cfg(2'd0, 32'h0);
    chk("R10 idle after abort", 32'(busy), 0);
    chk("R10 reg_valid dropped", 32'(reg_valid), 0);
    chk("R10 err_tail cleared", 32'(err_tail), 0);
    stall_reg = 1'b0;
    wait_cyc(20);
    chk("R10 no write leaks", 32'(wr_n - w0), 0);

    // R9 head equals tail, after abort recovery
    r0 = nreads;
    launch(32'h300, 32'h300, 32'h1);
    wait_idle();
    chk("R9 empty run idle", 32'(busy), 0);
    chk("R9 empty run no reads", 32'(nreads - r0), 0);

    // R10 recovery: normal run after abort
    clear_mem();
    put(32'h000, 32'h77); put(32'h004, 32'h01F00B00);
    w0 = wr_n;
    launch(0, 32'h40, 32'h1);
    wait_idle();
    chk("R10 run after abort count", 32'(wr_n - w0), 1);
    chk("R10 run after abort data", lg_d[w0[5:0]], 32'h77);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule